// File: doc/BRIEF.md
# External Interrupt Controller with Trigger Config

The controller receives 32 asynchronous interrupt pins from outside the chip and turns each one into an interrupt request for a downstream distributor. Every pin first passes through a two-flop synchronizer. It is then tested against its own trigger type: rising, falling, either edge, level low or level high. The result is captured in a pending flag and gated by a mask bit.

Pins are handled in four banks of eight, and all banks share one register layout. A word-addressed register bus reaches three register groups: trigger configuration, mask and pending. Pending flags read back raw, whatever the mask holds. Software clears them by writing ones. Pins 0 to 15 each own a request line. Pins 16 to 31 share one combined line, which is high whenever any unmasked pending flag in banks 2 or 3 is set.

Top module: `ext_irq_ctrl`

## Requirements
- R1: While reset is held, and right after it: every mask reads 0x000000FF, every pending and configuration register reads 0, and `irq_lo`/`irq_hi` are low.
- R2: Word index 0 to 3 (byte offsets 0x00 to 0x0C) holds the 32-bit configuration of banks 0 to 3 and reads back as written. Pin p takes its trigger code from bits [(p mod 8)*4 +: 3] of bank p/8. Bit 3 of each nibble is stored but unused.
- R3: Code 3'b011 (rising): a 0-to-1 change on a pin sets its pending flag at the third rising clock edge after the change. The flag stays set after the pin falls, until it is cleared.
- R4: Code 3'b010 (falling) sets the flag only on a 1-to-0 change. Code 3'b100 (both) sets it on either change. Both use the same three-edge latency as R3 and are sticky.
- R5: Codes 3'b000 (level low) and 3'b001 (level high): the pending flag follows the synchronized pin level, three edges behind the pin. A clear write does not drop it while the level is active.
- R6: Codes 3'b101 to 3'b111 never set a pending flag. A flag already set in these modes holds until cleared.
- R7: Word index 4 to 7 (offsets 0x10 to 0x1C) holds the masks in bits [7:0], and the upper bits read 0. A 1 blocks the pin's request, but the pending register still shows the raw flag.
- R8: Word index 8 to 11 (offsets 0x20 to 0x2C) reads the pending flags in bits [7:0]. Writing 1 to a bit clears that flag in edge and disabled modes. Writing 0, or writing to bits [31:8], has no effect.
- R9: If a set event and a clearing write hit the same flag in the same cycle, the flag ends up set.
- R10: `irq_lo[i]` is high exactly when pending flag i is set and mask bit i is 0, for pins 0 to 15. It changes in the same cycle as the flag.
- R11: `irq_hi` is high exactly when at least one of pins 16 to 31 has its pending flag set and its mask bit clear.
- R12: Word indices 12 to 15 read 0, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_i | input | 32 | Asynchronous external interrupt pins |
| bus_wr | input | 1 | Write strobe for one cycle |
| bus_addr | input | 4 | Word index (byte offset / 4) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| irq_lo | output | 16 | Dedicated requests for pins 0 to 15 |
| irq_hi | output | 1 | Combined request for pins 16 to 31 |

## Verification
All state sits in registers that can be read in the same cycle, so a corrupted pending flag, mask or configuration shows on `bus_rdata` and on the request lines at the very next sample. A fault in the synchronizer or edge history shows differently: the flag's three-edge latency shifts, or an edge is missed, and a cycle-by-cycle comparison against a model built from the requirements catches this within one sample of the expected set. Directed cases pin down the set-beats-clear collision and the behaviour of level modes under clearing writes. Both would otherwise show only as a flag that is one cycle early or late.

// File: rtl/ext_irq_ctrl.sv
module ext_irq_ctrl #(
  parameter int NPINS     = 32,
  parameter int BANK_PINS = 8,
  parameter int DIRECT    = 16,
  parameter int SLOT_W    = 4,
  parameter int AW        = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NPINS-1:0]  pin_i,
  input  logic              bus_wr,
  input  logic [AW-1:0]     bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic [DIRECT-1:0] irq_lo,
  output logic              irq_hi
);
  localparam int NBANK  = NPINS / BANK_PINS;
  localparam int BSEL_W = $clog2(NBANK);

  logic [NPINS-1:0] meta_q, sync_q, prev_q, pend_q, mask_q;
  logic [NPINS-1:0] hit, level, clr, pend_d, act;
  logic [NPINS-1:0][2:0] mode;
  logic [NBANK-1:0][31:0] cfg_q;
  logic [1:0] region;
  logic [BSEL_W-1:0] bank;

  assign region = bus_addr[AW-1 -: 2];
  assign bank   = bus_addr[BSEL_W-1:0];

  for (genvar g = 0; g < NPINS; g++) begin : g_pin
    assign mode[g]  = cfg_q[g / BANK_PINS][(g % BANK_PINS) * SLOT_W +: 3];
    assign hit[g]   = (mode[g] == 3'd0) ? ~sync_q[g] :
                      (mode[g] == 3'd1) ?  sync_q[g] :
                      (mode[g] == 3'd2) ? (prev_q[g] & ~sync_q[g]) :
                      (mode[g] == 3'd3) ? (sync_q[g] & ~prev_q[g]) :
                      (mode[g] == 3'd4) ? (sync_q[g] ^ prev_q[g]) : 1'b0;
    assign level[g] = (mode[g] == 3'd0) || (mode[g] == 3'd1);
    assign clr[g]   = bus_wr && (region == 2'd2) &&
                      (bank == BSEL_W'(g / BANK_PINS)) && bus_wdata[g % BANK_PINS];
    assign pend_d[g] = hit[g] | (~level[g] & pend_q[g] & ~clr[g]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      sync_q <= '0;
      prev_q <= '0;
      pend_q <= '0;
      mask_q <= '1;
      cfg_q  <= '0;
    end else begin
      meta_q <= pin_i;
      sync_q <= meta_q;
      prev_q <= sync_q;
      pend_q <= pend_d;
      if (bus_wr && region == 2'd0)
        cfg_q[bank] <= bus_wdata;
      if (bus_wr && region == 2'd1)
        mask_q[bank * BANK_PINS +: BANK_PINS] <= bus_wdata[BANK_PINS-1:0];
    end
  end

  always_comb begin
    bus_rdata = '0;
    case (region)
      2'd0:    bus_rdata = cfg_q[bank];
      2'd1:    bus_rdata[BANK_PINS-1:0] = mask_q[bank * BANK_PINS +: BANK_PINS];
      2'd2:    bus_rdata[BANK_PINS-1:0] = pend_q[bank * BANK_PINS +: BANK_PINS];
      default: bus_rdata = '0;
    endcase
  end

  assign act    = pend_q & ~mask_q;
  assign irq_lo = act[DIRECT-1:0];
  assign irq_hi = |act[NPINS-1:DIRECT];
endmodule

// File: rtl/ext_irq_ctrl_chk.sv
module ext_irq_ctrl_chk #(
  parameter int NPINS     = 32,
  parameter int BANK_PINS = 8,
  parameter int DIRECT    = 16,
  parameter int AW        = 4
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  bus_wr,
  input logic [AW-1:0]         bus_addr,
  input logic [BANK_PINS-1:0]  bus_wdata,
  input logic [DIRECT-1:0]     irq_lo,
  input logic                  irq_hi,
  input logic [NPINS-1:0][2:0] mode,
  input logic [NPINS-1:0]      mask_q,
  input logic [NPINS-1:0]      pend_q,
  input logic [NPINS-1:0]      sync_q,
  input logic [NPINS-1:0]      prev_q
);
  localparam int BSEL_W = $clog2(NPINS / BANK_PINS);

  for (genvar p = 0; p < NPINS; p++) begin : g_chk
    logic clear_hit;
    assign clear_hit = bus_wr && (bus_addr[AW-1 -: 2] == 2'd2) &&
                       (bus_addr[BSEL_W-1:0] == BSEL_W'(p / BANK_PINS)) &&
                       bus_wdata[p % BANK_PINS];

    AST_EDGE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      ((mode[p] == 3'd2 || mode[p] == 3'd3 || mode[p] == 3'd4) && pend_q[p] && !clear_hit) |=> pend_q[p]); // R3
    AST_LEVEL_HIGH_SETS: assert property (@(posedge clk) disable iff (!rst_n)
      (mode[p] == 3'd1 && sync_q[p]) |=> pend_q[p]); // R5
    AST_LEVEL_LOW_SETS: assert property (@(posedge clk) disable iff (!rst_n)
      (mode[p] == 3'd0 && !sync_q[p]) |=> pend_q[p]); // R5
    AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (mode[p] > 3'd4 && !pend_q[p]) |=> !pend_q[p]); // R6
    AST_SET_BEATS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      (mode[p] == 3'd3 && sync_q[p] && !prev_q[p] && clear_hit) |=> pend_q[p]); // R9
  end

  for (genvar q = 0; q < DIRECT; q++) begin : g_lo
    AST_MASK_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
      mask_q[q] |-> !irq_lo[q]); // R7
  end

  AST_HI_ALL_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    (&mask_q[NPINS-1:DIRECT]) |-> !irq_hi); // R11
endmodule

bind ext_irq_ctrl ext_irq_ctrl_chk #(
  .NPINS(NPINS), .BANK_PINS(BANK_PINS), .DIRECT(DIRECT), .AW(AW)
) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata[BANK_PINS-1:0]), .irq_lo(irq_lo), .irq_hi(irq_hi),
  .mode(mode), .mask_q(mask_q), .pend_q(pend_q), .sync_q(sync_q), .prev_q(prev_q)
);

// File: tb/ext_irq_ctrl_bench.sv
`timescale 1ns/1ps
module ext_irq_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] pin_i = '0;
  logic        bus_wr = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [15:0] irq_lo;
  logic        irq_hi;

  int total = 0;
  int fails = 0;

  always #5 clk = ~clk;

  ext_irq_ctrl u_ext_irq_ctrl (
    .clk(clk), .rst_n(rst_n), .pin_i(pin_i), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_lo(irq_lo), .irq_hi(irq_hi)
  );

  // Reference model built from the requirements
  logic [31:0] m_meta, m_sync, m_prev, m_pend, m_mask;
  logic [3:0][31:0] m_cfg;

  function automatic logic [31:0] f_next_pend(logic [3:0][31:0] cfg, logic [31:0] s,
      logic [31:0] pv, logic [31:0] pd, logic wr, logic [3:0] a, logic [31:0] d);
    logic [31:0] r;
    for (int p = 0; p < 32; p++) begin
      logic [2:0] md;
      logic h, c;
      md = cfg[p / 8][(p % 8) * 4 +: 3];
      case (md)
        3'd0: h = ~s[p];
        3'd1: h = s[p];
        3'd2: h = pv[p] & ~s[p];
        3'd3: h = s[p] & ~pv[p];
        3'd4: h = s[p] ^ pv[p];
        default: h = 1'b0;
      endcase
      c = wr && (a[3:2] == 2'd2) && (a[1:0] == 2'(p / 8)) && d[p % 8];
      r[p] = (md <= 3'd1) ? h : (h | (pd[p] & ~c));
    end
    return r;
  endfunction

  function automatic logic [31:0] f_read(logic [3:0] a, logic [3:0][31:0] cfg,
      logic [31:0] mk, logic [31:0] pd);
    case (a[3:2])
      2'd0:    return cfg[a[1:0]];
      2'd1:    return {24'd0, mk[a[1:0] * 8 +: 8]};
      2'd2:    return {24'd0, pd[a[1:0] * 8 +: 8]};
      default: return 32'd0;
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_meta <= '0; m_sync <= '0; m_prev <= '0; m_pend <= '0;
      m_mask <= '1; m_cfg <= '0;
    end else begin
      m_meta <= pin_i;
      m_sync <= m_meta;
      m_prev <= m_sync;
      m_pend <= f_next_pend(m_cfg, m_sync, m_prev, m_pend, bus_wr, bus_addr, bus_wdata);
      if (bus_wr && bus_addr[3:2] == 2'd0) m_cfg[bus_addr[1:0]] <= bus_wdata;
      if (bus_wr && bus_addr[3:2] == 2'd1) m_mask[bus_addr[1:0] * 8 +: 8] <= bus_wdata[7:0];
    end
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic rdchk(logic [3:0] a, logic [31:0] exp, string tag);
    bus_addr = a;
    #1;
    chk(tag, bus_rdata, exp);
  endtask

  task automatic wr(logic [3:0] a, logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic setpin(int idx, logic v);
    @(negedge clk);
    pin_i[idx] = v;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    #2_000_000;
    total++; fails++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    // R1 reset values, read while reset is held
    for (int b = 0; b < 4; b++) begin
      rdchk(4'(4 + b), 32'h0000_00FF, "R1 mask reset");
      rdchk(4'(8 + b), 32'h0, "R1 pend reset");
      rdchk(4'(b), 32'h0, "R1 cfg reset");
    end
    chk("R1 irq_lo reset", {16'd0, irq_lo}, 32'h0);
    chk("R1 irq_hi reset", {31'd0, irq_hi}, 32'h0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk("R1 outputs low after reset", {15'd0, irq_hi, irq_lo}, 32'h0);

    // Disable all, clear, unmask
    for (int b = 0; b < 4; b++) wr(4'(b), 32'h7777_7777);
    for (int b = 0; b < 4; b++) wr(4'(8 + b), 32'hFF);
    for (int b = 0; b < 4; b++) wr(4'(4 + b), 32'h0);
    rdchk(4'd1, 32'h7777_7777, "R2 cfg readback");
    for (int b = 0; b < 4; b++) rdchk(4'(8 + b), 32'h0, "R6 disabled quiet");
    chk("R10 irq_lo idle", {16'd0, irq_lo}, 32'h0);

    // R3 rising on pin 5
    wr(4'd0, 32'h7737_7777);
    setpin(5, 1'b1);
    rdchk(4'd8, 32'h20, "R3 rising sets");
    chk("R10 irq_lo pin5", {16'd0, irq_lo}, 32'h20);
    setpin(5, 1'b0);
    rdchk(4'd8, 32'h20, "R3 sticky after fall");
    wr(4'd8, 32'hFFFF_FFDF);
    rdchk(4'd8, 32'h20, "R8 zero write no effect");
    wr(4'd8, 32'h20);
    rdchk(4'd8, 32'h0, "R8 write one clears");

    // R4 falling on pin 9
    wr(4'd1, 32'h7777_7727);
    setpin(9, 1'b1);
    rdchk(4'd9, 32'h0, "R4 falling ignores rise");
    setpin(9, 1'b0);
    rdchk(4'd9, 32'h02, "R4 falling sets");
    chk("R10 irq_lo pin9", {16'd0, irq_lo}, 32'h200);
    wr(4'd9, 32'h02);

    // R4 both on pin 20
    wr(4'd2, 32'h7774_7777);
    setpin(20, 1'b1);
    rdchk(4'd10, 32'h10, "R4 both rise");
    chk("R11 irq_hi pin20", {31'd0, irq_hi}, 32'h1);
    wr(4'd10, 32'h10);
    rdchk(4'd10, 32'h0, "R8 clear edge flag");
    setpin(20, 1'b0);
    rdchk(4'd10, 32'h10, "R4 both fall");
    wr(4'd6, 32'h10);
    chk("R7 masked irq_hi", {31'd0, irq_hi}, 32'h0);
    rdchk(4'd10, 32'h10, "R7 raw pending under mask");
    wr(4'd6, 32'h0);
    wr(4'd10, 32'h10);

    // R5 level high on pin 31
    wr(4'd3, 32'h1777_7777);
    setpin(31, 1'b1);
    rdchk(4'd11, 32'h80, "R5 level high sets");
    wr(4'd11, 32'h80);
    rdchk(4'd11, 32'h80, "R5 clear ignored while active");
    setpin(31, 1'b0);
    rdchk(4'd11, 32'h0, "R5 follows level");

    // R9 set beats clear on pin 2 (rising)
    wr(4'd0, 32'h7777_7377);
    @(negedge clk);
    pin_i[2] = 1'b1;
    repeat (2) @(negedge clk);
    bus_wr = 1'b1; bus_addr = 4'd8; bus_wdata = 32'h04;
    @(negedge clk);
    bus_wr = 1'b0;
    rdchk(4'd8, 32'h04, "R9 set wins");
    pin_i[2] = 1'b0;
    wr(4'd8, 32'h04);

    // R5 level low on pin 0
    wr(4'd0, 32'h7777_7770);
    @(negedge clk);
    rdchk(4'd8, 32'h01, "R5 level low sets");
    setpin(0, 1'b1);
    rdchk(4'd8, 32'h0, "R5 level low drops");

    // R12 unmapped
    wr(4'd12, 32'hFFFF_FFFF);
    rdchk(4'd12, 32'h0, "R12 unmapped read");
    rdchk(4'd15, 32'h0, "R12 unmapped read");
    rdchk(4'd0, 32'h7777_7770, "R12 cfg unchanged");
    rdchk(4'd4, 32'h0, "R12 mask unchanged");

    // R7 upper mask bits
    wr(4'd5, 32'hFFFF_FF00);
    rdchk(4'd5, 32'h0, "R7 mask upper bits");
    wr(4'd5, 32'hAB);
    rdchk(4'd5, 32'hAB, "R7 mask low bits");
    wr(4'd5, 32'h0);

    // Random phase against the model
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      #1;
      chk("R10 irq_lo model", {16'd0, irq_lo}, {16'd0, (m_pend[15:0] & ~m_mask[15:0])});
      chk("R11 irq_hi model", {31'd0, irq_hi}, {31'd0, |(m_pend[31:16] & ~m_mask[31:16])});
      chk("R2 register read model", bus_rdata, f_read(bus_addr, m_cfg, m_mask, m_pend));
      pin_i = pin_i ^ ($urandom & $urandom & $urandom);
      bus_wr = ($urandom % 4) == 0;
      bus_addr = 4'($urandom);
      bus_wdata = $urandom;
    end
    @(negedge clk);
    bus_wr = 1'b0;

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule